// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Jam Controller

This block gives a half-duplex Ethernet MAC a way to hold back a remote sender when the local receive buffer is filling up. It compares the buffer's fill level with a programmable threshold. When the fill is at or above that threshold and a new incoming frame starts, it raises a one-cycle jam request. The transmit path answers that request with a jam pattern on the line. The remote station sees a collision and backs off. Because the request is only ever raised at the start of a received frame, a jam never lands late in a frame.

The block also counts collisions in a row. A run of collisions that is too long would make a repeater hub partition the port, so this count is capped. When the count reaches a programmable 8-bit limit, the controller stops jamming and lets incoming frames leak through, even when the buffer is still full. Any transmitted or received frame that completes without a collision clears the count, and jamming resumes. A limit of zero turns the cap off.

Top module: `bp_jam_ctrl`

## Requirements
- R1: After reset, jam_req is low and the count of collisions in a row is zero.
- R2: When rx_sof is high in a cycle where fill_level >= fill_thresh and leakage is not active, jam_req is high for exactly one cycle, in the cycle after rx_sof.
- R3: When fill_level < fill_thresh, rx_sof produces no jam request.
- R4: No jam request is raised in any cycle that does not follow an rx_sof pulse, whatever the fill level.
- R5: Each cycle with coll_det high adds one to the count, and the count saturates at jam_limit without wrapping. Leakage is active while jam_limit is nonzero and the count is >= jam_limit. While leakage is active, rx_sof raises no jam request.
- R6: A tx_done_ok or rx_done_ok pulse clears the count to zero, which also ends leakage. When a clean completion and coll_det arrive in the same cycle, the clear wins.
- R7: When jam_limit is zero, leakage never becomes active and the count does not advance.
- R8: If jam_limit is lowered to a value at or below the current count, leakage takes effect at once.
- R9: A fill level exactly equal to fill_thresh counts as over the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_level | input | LVL_W | Current receive buffer fill |
| fill_thresh | input | LVL_W | Fill level at or above which back-pressure applies |
| jam_limit | input | LIM_W | Collisions in a row before leakage; 0 disables leakage |
| rx_sof | input | 1 | One-cycle pulse at the start of an incoming frame |
| coll_det | input | 1 | One-cycle pulse per detected collision |
| tx_done_ok | input | 1 | A transmitted frame completed without a collision |
| rx_done_ok | input | 1 | A received frame completed without a collision |
| jam_req | output | 1 | One-cycle request to the transmit path to send a jam |

## Verification
The hardest states to reach from the ports involve the saturating counter. From outside, a count held at the limit looks the same as a count that ran past it. The stimulus therefore drives many more collisions than the limit and then raises the limit. Afterwards, the number of further collisions that are needed before jamming stops shows where the count actually stopped. Lowering the limit below a count that is already held, and driving a clean completion in the same cycle as a collision, reach the two remaining corners: leakage that begins at once, and the clear taking priority.

// File: rtl/bp_jam_pkg.sv
package bp_jam_pkg;

  // Over-threshold test: equal counts as over.
  function automatic logic fill_over(input logic [31:0] level, input logic [31:0] thresh);
    return level >= thresh;
  endfunction

  // Next value of the collision streak counter.
  function automatic logic [7:0] streak_next(
    input logic [7:0] cnt,
    input logic [7:0] lim,
    input logic       clean,
    input logic       coll
  );
    logic [7:0] r;
    r = cnt;
    if (clean)                 r = '0;
    else if (coll && cnt < lim) r = cnt + 8'd1;
    return r;
  endfunction

  // Leakage: a nonzero limit that has been reached.
  function automatic logic leak_on(input logic [7:0] cnt, input logic [7:0] lim);
    return (lim != 8'd0) && (cnt >= lim);
  endfunction

endpackage

// File: rtl/bp_fill_cmp.sv
module bp_fill_cmp #(
  parameter int LVL_W = 12
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             over
);
  import bp_jam_pkg::*;

  localparam int PAD = 32 - LVL_W;

  always_comb begin
    over = fill_over({{PAD{1'b0}}, level}, {{PAD{1'b0}}, thresh});
  end
endmodule

// File: rtl/bp_streak_cnt.sv
module bp_streak_cnt #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] limit,
  input  logic             clean,
  input  logic             coll,
  output logic [LIM_W-1:0] cnt,
  output logic             leak
);
  import bp_jam_pkg::*;

  logic [LIM_W-1:0] cnt_d;

  always_comb begin
    cnt_d = streak_next(cnt, limit, clean, coll);
    leak  = leak_on(cnt, limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/bp_jam_pulse.sv
module bp_jam_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  input  logic over,
  input  logic leak,
  output logic fire,
  output logic req
);
  always_comb begin
    fire = sof && over && !leak;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= fire;
  end
endmodule

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl #(
  parameter int LVL_W = 12,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] fill_thresh,
  input  logic [LIM_W-1:0] jam_limit,
  input  logic             rx_sof,
  input  logic             coll_det,
  input  logic             tx_done_ok,
  input  logic             rx_done_ok,
  output logic             jam_req
);
  // Named internal events, observed by the bound checker.
  logic             over_w;
  logic             leak_w;
  logic             clean_w;
  logic             fire_w;
  logic [LIM_W-1:0] cnt_q;

  assign clean_w = tx_done_ok | rx_done_ok;

  bp_fill_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level (fill_level),
    .thresh(fill_thresh),
    .over  (over_w)
  );

  bp_streak_cnt #(.LIM_W(LIM_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .limit(jam_limit),
    .clean(clean_w),
    .coll (coll_det),
    .cnt  (cnt_q),
    .leak (leak_w)
  );

  bp_jam_pulse u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .sof  (rx_sof),
    .over (over_w),
    .leak (leak_w),
    .fire (fire_w),
    .req  (jam_req)
  );
endmodule

// File: rtl/bp_jam_ctrl_chk.sv
module bp_jam_ctrl_chk #(
  parameter int LIM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LIM_W-1:0] jam_limit,
  input logic             rx_sof,
  input logic             coll_det,
  input logic             jam_req,
  input logic             over_w,
  input logic             leak_w,
  input logic             clean_w,
  input logic [LIM_W-1:0] cnt_q
);
  // R2
  jam_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> ($past(rx_sof) && $past(over_w) && !$past(leak_w)));

  // R4
  no_midframe_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_sof) |-> !jam_req);

  // R5
  leak_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && leak_w) |=> !jam_req);

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_det && !clean_w && jam_limit != '0 && cnt_q >= jam_limit) |=> (cnt_q == $past(cnt_q)));

  // R6
  clean_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clean_w |=> (cnt_q == '0 && !leak_w) || (jam_limit == '0 && !leak_w) || (cnt_q == '0));

  // R7
  nolimit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_limit == '0) |-> !leak_w);
endmodule

bind bp_jam_ctrl bp_jam_ctrl_chk #(.LIM_W(LIM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .jam_limit(jam_limit),
  .rx_sof   (rx_sof),
  .coll_det (coll_det),
  .jam_req  (jam_req),
  .over_w   (over_w),
  .leak_w   (leak_w),
  .clean_w  (clean_w),
  .cnt_q    (cnt_q)
);

// File: tb/bp_jam_ctrl_tb.sv
module bp_jam_ctrl_tb;
  localparam int LVL_W = 12;
  localparam int LIM_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] fill_level = '0;
  logic [LVL_W-1:0] fill_thresh = '0;
  logic [LIM_W-1:0] jam_limit = '0;
  logic             rx_sof = 1'b0;
  logic             coll_det = 1'b0;
  logic             tx_done_ok = 1'b0;
  logic             rx_done_ok = 1'b0;
  logic             jam_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bp_jam_ctrl #(.LVL_W(LVL_W), .LIM_W(LIM_W)) u_dut (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: jam_req actual %b expected %b", req, act, exp);
    end
  endtask

  // Pulse rx_sof for one cycle; expect jam in the next cycle only when want is set.
  task automatic sof_probe(input string req, input logic want);
    @(negedge clk); rx_sof = 1'b1;
    @(negedge clk); rx_sof = 1'b0;
    check(req, jam_req, want);
    @(negedge clk);
    check(req, jam_req, 1'b0);
  endtask

  task automatic collide(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); coll_det = 1'b1;
      @(negedge clk); coll_det = 1'b0;
    end
  endtask

  task automatic clean_tx();
    @(negedge clk); tx_done_ok = 1'b1;
    @(negedge clk); tx_done_ok = 1'b0;
  endtask

  task automatic clean_rx();
    @(negedge clk); rx_done_ok = 1'b1;
    @(negedge clk); rx_done_ok = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset", jam_req, 1'b0);
    rst_n = 1'b1;
    fill_thresh = 12'd100; fill_level = 12'd200; jam_limit = 8'd1;
    sof_probe("R1 count starts at zero", 1'b1);
  endtask

  task automatic t_basic();
    jam_limit = 8'd3;
    sof_probe("R2 jam on full buffer", 1'b1);
    fill_level = 12'd99;
    sof_probe("R3 below threshold", 1'b0);
    fill_level = 12'd100;
    sof_probe("R9 equal to threshold", 1'b1);
  endtask

  task automatic t_nosof();
    fill_level = 12'd4000;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R4 no jam without frame start", jam_req, 1'b0);
    end
  endtask

  task automatic t_leak();
    jam_limit = 8'd3;
    collide(2);
    sof_probe("R5 below limit still jams", 1'b1);
    collide(1);
    sof_probe("R5 leakage at limit", 1'b0);
    collide(20);
    jam_limit = 8'd5;
    sof_probe("R5 saturated count below raised limit", 1'b1);
    collide(1);
    sof_probe("R5 one under raised limit", 1'b1);
    collide(1);
    sof_probe("R5 leakage at raised limit", 1'b0);
    clean_tx();
    sof_probe("R6 clean transmit clears", 1'b1);
    collide(5);
    sof_probe("R6 leakage again", 1'b0);
    clean_rx();
    sof_probe("R6 clean receive clears", 1'b1);
  endtask

  task automatic t_same_cycle();
    jam_limit = 8'd1;
    @(negedge clk); coll_det = 1'b1; rx_done_ok = 1'b1;
    @(negedge clk); coll_det = 1'b0; rx_done_ok = 1'b0;
    sof_probe("R6 clear beats collision", 1'b1);
  endtask

  task automatic t_nolimit();
    jam_limit = 8'd0;
    collide(300);
    sof_probe("R7 zero limit never leaks", 1'b1);
  endtask

  task automatic t_lower();
    jam_limit = 8'd10;
    collide(4);
    sof_probe("R8 under large limit", 1'b1);
    jam_limit = 8'd2;
    sof_probe("R8 limit lowered below count", 1'b0);
    clean_tx();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_nosof();
    t_leak();
    t_same_cycle();
    t_nolimit();
    t_lower();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule